// File: doc/BRIEF.md
# Sa6 Pattern Event Counter

This block counts receive-side events on an E1 line that runs in CRC-4 multiframe mode. Each multiframe has two submultiframes. In each submultiframe the block collects the four Sa6 spare bits, which arrive in the odd frames. It adds one to a live counter when the four bits, taken in arrival order, read 0010 or 0011. Counting happens only when CRC multiframe mode is selected and the receiver holds multiframe lock. An alarm-simulation flag changes the rule: the counter then steps once per multiframe, whatever the Sa6 content. The counter saturates and never wraps.

Software reads the count from a buffer, presented as a high byte and a low byte. Two readout schemes are available:

- **Manual scheme.** The buffer follows the live count. Setting a freeze control stops the buffer and clears the live counter. Reading the high byte releases the freeze.
- **One-second scheme.** Each one-second tick copies the live count into the buffer, clears the live counter and raises a one-cycle interrupt.

Top module: `sa6_err_counter`

## Requirements
- R1: Frames are numbered 0 to 15 within a multiframe, and each frame is marked by `frame_stb` together with `frame_idx` and `sa6_bit`. The first submultiframe takes its Sa6 bits from frames 1, 3, 5 and 7, in that order. The second takes them from frames 9, 11, 13 and 15. A submultiframe whose bits read 0010 or 0011 (first bit leftmost) adds exactly one to the count. Every other pattern adds nothing.
- R2: A submultiframe counts only if all four of its odd-frame strobes arrive in sequence. If one is missing, that submultiframe adds nothing.
- R3: While `crc_mode` is 0 (double-frame format), neither pattern matches nor alarm simulation change the count.
- R4: A submultiframe whose fourth Sa6 bit arrives while `mf_locked` is 0 adds nothing.
- R5: While `alarm_sim` is 1, the count rises by exactly one per multiframe, on the frame-15 strobe, whatever the Sa6 bits are.
- R6: The count saturates at 2^CNT_W-1 and holds there rather than wrapping.
- R7: In the manual scheme (`sec_mode`=0) with no freeze active, the buffer `{cnt_hi,cnt_lo}` follows the live count, one cycle behind. `cnt_hi` carries count bits above bit 7, zero-filled.
- R8: In the manual scheme, a `freeze_set` pulse while not frozen does three things. It loads the buffer with the live count, clears the live count and sets `frozen`. The buffer then holds.
- R9: A `hi_read` pulse while frozen clears `frozen`, and the buffer resumes following the live count.
- R10: In the one-second scheme, a `sec_tick` pulse does three things. It copies the live count into the buffer, clears the live count and pulses `sec_irq` high for one cycle in the next cycle. The buffer holds between ticks, and the freeze control is ignored.
- R11: If an increment coincides with a clear, the live count restarts at 1 and the event is kept.
- R12: After reset the buffer, `frozen` and `sec_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle marker of a received frame |
| frame_idx | input | 4 | Frame number within the multiframe, 0 to 15 |
| sa6_bit | input | 1 | Sa6 bit of the marked frame |
| mf_locked | input | 1 | Receiver holds multiframe lock |
| crc_mode | input | 1 | 1 = CRC-4 multiframe mode, 0 = double-frame format |
| alarm_sim | input | 1 | Alarm simulation: count once per multiframe |
| sec_tick | input | 1 | One-second tick pulse |
| sec_mode | input | 1 | 1 = one-second readout, 0 = manual readout |
| freeze_set | input | 1 | Pulse that requests a freeze (manual scheme) |
| hi_read | input | 1 | Pulse that marks a read of the high byte |
| cnt_hi | output | 8 | Buffered count, upper byte |
| cnt_lo | output | 8 | Buffered count, lower byte |
| frozen | output | 1 | Freeze is active |
| sec_irq | output | 1 | One-second interrupt pulse |

## Verification
The bench sweeps all 256 combinations of the two submultiframe patterns. A decoder that reads the bits in reverse order, or that accepts only one of the two patterns, gives a running total that drifts from the computed sum.

A dropped frame-5 strobe catches a collector that does not check the sequence, because it would count stale bits. A long alarm-simulation run on an 8-bit count exposes any counter that wraps to zero instead of holding.

The bench also places a one-second tick in the same cycle as a pending increment. A design that lets the clear win loses the event and the next tick reads 0. A design that applies both ends up at a double count.

// File: rtl/sa6_pkg.sv
package sa6_pkg;
   localparam int unsigned SA6_MAX_W   = 16;
   localparam int unsigned SA6_MIN_W   = 4;
   localparam int unsigned SA6_BYTE_W  = 8;
   localparam int unsigned SA6_LAST_FR = 15;

   typedef enum logic {
      RD_MANUAL = 1'b0,
      RD_SECOND = 1'b1
   } rd_scheme_e;

   // first three Sa6 bits that select the two counted patterns
   localparam logic [2:0] SA6_PREFIX = 3'b001;
endpackage

// File: rtl/sa6_pattern_tracker.sv
module sa6_pattern_tracker
   import sa6_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_stb,
   input  logic [3:0] frame_idx,
   input  logic       sa6_bit,
   input  logic       mf_locked,
   output logic       smf_hit,
   output logic       mf_end
);
   logic [1:0] slot;
   logic       odd_fr;
   logic [1:0] have_q;
   logic [2:0] bits_q;

   assign odd_fr = frame_idx[0];
   assign slot   = frame_idx[2:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q  <= '0;
         bits_q  <= '0;
         smf_hit <= 1'b0;
         mf_end  <= 1'b0;
      end else begin
         smf_hit <= 1'b0;
         mf_end  <= frame_stb && (frame_idx == 4'(SA6_LAST_FR));
         if (frame_stb && odd_fr) begin
            if (slot == 2'd0) begin
               bits_q[2] <= sa6_bit;
               have_q    <= 2'd1;
            end else if (slot != have_q) begin
               have_q <= 2'd0;
            end else if (slot == 2'd3) begin
               smf_hit <= mf_locked && (bits_q == SA6_PREFIX);
               have_q  <= 2'd0;
            end else begin
               bits_q[2 - slot] <= sa6_bit;
               have_q           <= have_q + 2'd1;
            end
         end
      end
   end

   // R1
   hit_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smf_hit |-> $past(frame_stb && frame_idx[0] && frame_idx[2:1] == 2'd3));

   // R4
   hit_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smf_hit |-> $past(mf_locked));
endmodule

// File: rtl/sa6_sat_counter.sv
module sa6_sat_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_d;

   always_comb begin
      if (clr)
         cnt_d = inc ? W'(1) : '0;
      else if (inc && cnt != TOP)
         cnt_d = cnt + W'(1);
      else
         cnt_d = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP && !clr) |=> cnt == TOP);

   // R1
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt != TOP) |=> cnt == $past(cnt) + W'(1));

   // R11
   clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == W'($past(inc)));
endmodule

// File: rtl/sa6_readout.sv
module sa6_readout
   import sa6_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sec_mode,
   input  logic         sec_tick,
   input  logic         freeze_set,
   input  logic         hi_read,
   input  logic [W-1:0] live,
   output logic [W-1:0] buf_q,
   output logic         frozen,
   output logic         sec_irq,
   output logic         clr_live
);
   rd_scheme_e scheme;
   logic       freeze_rise;
   logic       load;

   assign scheme      = rd_scheme_e'(sec_mode);
   assign freeze_rise = (scheme == RD_MANUAL) && freeze_set && !frozen;
   assign clr_live    = (scheme == RD_SECOND) ? sec_tick : freeze_rise;
   assign load        = (scheme == RD_SECOND) ? sec_tick : !frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         frozen  <= 1'b0;
         sec_irq <= 1'b0;
      end else begin
         sec_irq <= (scheme == RD_SECOND) && sec_tick;
         if (load) buf_q <= live;
         if (scheme == RD_SECOND)
            frozen <= 1'b0;
         else if (freeze_rise)
            frozen <= 1'b1;
         else if (hi_read)
            frozen <= 1'b0;
      end
   end

   // R8
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !hi_read && !sec_mode) |=> $stable(buf_q));

   // R10
   sec_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_mode && sec_tick) |=> sec_irq);

   // R10
   sec_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_irq |-> $past(sec_mode && sec_tick));

   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && hi_read && !freeze_set) |=> !frozen);
endmodule

// File: rtl/sa6_err_counter.sv
module sa6_err_counter
   import sa6_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_stb,
   input  logic [3:0] frame_idx,
   input  logic       sa6_bit,
   input  logic       mf_locked,
   input  logic       crc_mode,
   input  logic       alarm_sim,
   input  logic       sec_tick,
   input  logic       sec_mode,
   input  logic       freeze_set,
   input  logic       hi_read,
   output logic [7:0] cnt_hi,
   output logic [7:0] cnt_lo,
   output logic       frozen,
   output logic       sec_irq
);
   localparam int unsigned HI_W = (CNT_W > SA6_BYTE_W) ? CNT_W - SA6_BYTE_W : 1;

   generate
      if (CNT_W < SA6_MIN_W || CNT_W > SA6_MAX_W) begin : g_bad_width
         $error("sa6_err_counter: CNT_W out of range");
      end
   endgenerate

   logic             smf_hit;
   logic             mf_end;
   logic             inc;
   logic             clr_live;
   logic [CNT_W-1:0] live;
   logic [CNT_W-1:0] buf_q;

   sa6_pattern_tracker i_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .frame_idx (frame_idx),
      .sa6_bit   (sa6_bit),
      .mf_locked (mf_locked),
      .smf_hit   (smf_hit),
      .mf_end    (mf_end)
   );

   assign inc = crc_mode && (alarm_sim ? mf_end : smf_hit);

   sa6_sat_counter #(.W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc),
      .clr   (clr_live),
      .cnt   (live)
   );

   sa6_readout #(.W(CNT_W)) i_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_mode   (sec_mode),
      .sec_tick   (sec_tick),
      .freeze_set (freeze_set),
      .hi_read    (hi_read),
      .live       (live),
      .buf_q      (buf_q),
      .frozen     (frozen),
      .sec_irq    (sec_irq),
      .clr_live   (clr_live)
   );

   generate
      if (CNT_W > SA6_BYTE_W) begin : g_two_bytes
         logic [HI_W-1:0] hi_part;
         assign hi_part = buf_q[CNT_W-1:SA6_BYTE_W];
         assign cnt_hi  = 8'(hi_part);
         assign cnt_lo  = buf_q[SA6_BYTE_W-1:0];
      end else begin : g_one_byte
         assign cnt_hi = '0;
         assign cnt_lo = 8'(buf_q);
      end
   endgenerate

   // R3
   dbl_frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!crc_mode && !clr_live) |=> $stable(live));

   // R5
   alarm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_mode && alarm_sim && !mf_end && !clr_live) |=> $stable(live));
endmodule

// File: tb/test_sa6_err_counter.sv
module test_sa6_err_counter;
   localparam int unsigned W = 8;
   localparam int TOPV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0;
   logic [3:0] frame_idx = '0;
   logic sa6_bit = 1'b1;
   logic mf_locked = 1'b1;
   logic crc_mode = 1'b1;
   logic alarm_sim = 1'b0;
   logic sec_tick = 1'b0;
   logic sec_mode = 1'b0;
   logic freeze_set = 1'b0;
   logic hi_read = 1'b0;
   logic [7:0] cnt_hi, cnt_lo;
   logic frozen, sec_irq;

   int checks = 0;
   int fails = 0;
   int expv = 0;

   always #5ns clk = ~clk;

   sa6_err_counter #(.CNT_W(W)) i_sa6_err_counter (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_idx(frame_idx),
      .sa6_bit(sa6_bit), .mf_locked(mf_locked), .crc_mode(crc_mode),
      .alarm_sim(alarm_sim), .sec_tick(sec_tick), .sec_mode(sec_mode),
      .freeze_set(freeze_set), .hi_read(hi_read), .cnt_hi(cnt_hi),
      .cnt_lo(cnt_lo), .frozen(frozen), .sec_irq(sec_irq)
   );

   task automatic chk(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   function automatic int bufv();
      return {cnt_hi, cnt_lo};
   endfunction

   function automatic int match(input logic [3:0] p);
      return (p[3:1] == 3'b001) ? 1 : 0;
   endfunction

   task automatic frame(input int idx, input logic b);
      @(negedge clk);
      frame_stb = 1'b1;
      frame_idx = 4'(idx);
      sa6_bit = b;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   function automatic logic bit_for(input int idx, input logic [3:0] a, input logic [3:0] b);
      if (idx[0] == 1'b0) return 1'b1;
      if (idx < 8) return a[3 - idx/2];
      return b[3 - (idx - 8)/2];
   endfunction

   task automatic send_mf(input logic [3:0] a, input logic [3:0] b, input bit skip5);
      for (int i = 0; i < 16; i++) begin
         if (!(skip5 && i == 5)) frame(i, bit_for(i, a, b));
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_freeze();
      @(negedge clk); freeze_set = 1'b1;
      @(negedge clk); freeze_set = 1'b0;
   endtask

   task automatic pulse_hiread();
      @(negedge clk); hi_read = 1'b1;
      @(negedge clk); hi_read = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 buffer", bufv(), 0);
      chk("R12 frozen", frozen, 0);
      chk("R12 sec_irq", sec_irq, 0);
      rst_n = 1'b1;
      settle();

      // R1 R7 exhaustive pattern sweep, buffer tracks live
      expv = 0;
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            send_mf(4'(a), 4'(b), 1'b0);
            expv += match(4'(a)) + match(4'(b));
            settle();
            chk("R1 R7 sweep count", bufv(), expv);
         end
      end
      chk("R7 high byte zero fill", cnt_hi, 0);

      // R2 missing frame-5 strobe
      send_mf(4'b0010, 4'b0011, 1'b1);
      expv += 1;
      settle();
      chk("R2 incomplete submultiframe", bufv(), expv);

      // R4 out of lock
      mf_locked = 1'b0;
      send_mf(4'b0010, 4'b0011, 1'b0);
      settle();
      chk("R4 unlocked ignored", bufv(), expv);
      mf_locked = 1'b1;

      // R3 double-frame format
      crc_mode = 1'b0;
      send_mf(4'b0010, 4'b0011, 1'b0);
      alarm_sim = 1'b1;
      send_mf(4'b0000, 4'b0000, 1'b0);
      alarm_sim = 1'b0;
      settle();
      chk("R3 double-frame no count", bufv(), expv);
      crc_mode = 1'b1;

      // R8 freeze
      pulse_freeze();
      chk("R8 frozen set", frozen, 1);
      chk("R8 buffer captured", bufv(), expv);
      send_mf(4'b0011, 4'b0010, 1'b0);
      settle();
      chk("R8 buffer holds", bufv(), expv);
      // R9 release
      pulse_hiread();
      chk("R9 frozen cleared", frozen, 0);
      settle();
      chk("R9 buffer resumes from cleared live", bufv(), 2);

      // R5 R6 alarm simulation and saturation
      pulse_freeze();
      pulse_hiread();
      settle();
      chk("R8 live cleared", bufv(), 0);
      alarm_sim = 1'b1;
      for (int k = 0; k < 10; k++) send_mf(4'b0010, 4'b0010, 1'b0);
      settle();
      chk("R5 once per multiframe", bufv(), 10);
      for (int k = 0; k < 290; k++) send_mf(4'b0000, 4'b0000, 1'b0);
      settle();
      chk("R6 saturated", bufv(), TOPV);
      send_mf(4'b0000, 4'b0000, 1'b0);
      settle();
      chk("R6 holds at max", bufv(), TOPV);
      alarm_sim = 1'b0;

      // R10 one-second scheme
      sec_mode = 1'b1;
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      chk("R10 irq pulse", sec_irq, 1);
      chk("R10 buffer loaded", bufv(), TOPV);
      @(negedge clk);
      chk("R10 irq single cycle", sec_irq, 0);
      send_mf(4'b0010, 4'b0011, 1'b0);
      send_mf(4'b0011, 4'b0111, 1'b0);
      settle();
      chk("R10 buffer holds between ticks", bufv(), TOPV);
      pulse_freeze();
      chk("R10 freeze ignored", frozen, 0);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      chk("R10 second tick value", bufv(), 3);

      // R11 coincident increment and clear
      send_mf(4'b0010, 4'b0011, 1'b0);
      for (int i = 0; i < 7; i++) frame(i, bit_for(i, 4'b0010, 4'b0000));
      frame(7, 1'b0);
      sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      chk("R11 buffer before event", bufv(), 2);
      for (int i = 8; i < 16; i++) frame(i, bit_for(i, 4'b0010, 4'b0000));
      settle();
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      chk("R11 event kept", bufv(), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule